// File: doc/BRIEF.md
# Profiling Control Register Access Gate

This block judges a single system-register access to the profiling control register. The access can be a read or a write, through either the primary encoding or the alias encoding. For each request it picks exactly one of five outcomes:

- the instruction is undefined;
- the access traps to level 2;
- the access traps to level 3;
- the access is redirected to a memory slot;
- the access proceeds to a physical register, which is either the level-1 copy or the level-2 copy.

The decision takes into account:

- the current privilege level;
- whether levels 2 and 3 are enabled or present;
- the security-state bits;
- the level-3 buffer-ownership controls;
- the fine-grained and coarse trap bits;
- the effective nested-virtualization bits;
- the host-mode flag;
- two feature flags.

The decision logic is purely combinational. The result is captured once per request strobe and is presented with a one-cycle valid pulse. The core pipeline samples the result before it either takes an exception or completes the register access. Register storage and exception entry are not part of this block.

Top module: `pmc_access_gate`

## Requirements
- R1: Any access made at level 0 (`req_level`=0) yields the undefined outcome, for both encodings.
- R2: An ownership mismatch exists only when level 3 is present and at least one of the following holds: `own_ctl[0]`=0; `own_ctl[1]`≠`sec_ns`; or `realm_impl`=1 and `own_ext`≠`sec_ext`. Under the primary encoding at levels 1 and 2, a mismatch with `undef_prio`=1 is undefined ahead of every other check.
- R3: Under the primary encoding at level 1, a trap to level 2 results when all of these hold: the fine-grained bit for the access direction is set (`fgt_rd_trap` for reads, `fgt_wr_trap` for writes), `l2_enabled`=1, `fgt_impl`=1, and either level 3 is absent or `fgt_enable`=1. The bit for the other direction has no effect.
- R4: Under the primary encoding at level 1, and only after the R2 and R3 checks, `coarse_trap`=1 with `l2_enabled`=1 traps to level 2.
- R5: After R2 to R4, an ownership mismatch gives a trap to level 3, or the undefined outcome when `dd_undef`=1. This applies at level 1, at level 2, and for the alias encoding at level 2.
- R6: Under the primary encoding at level 1, once no earlier check has hit, `nv_ctl`=3'b111 redirects to the memory slot and `rsp_target` carries the offset 0x828. Any other value reaches the level-1 register, with `rsp_target`=0.
- R7: Under the primary encoding at level 2, once the R2 and R5 checks pass, `host_mode`=1 reaches the level-2 register (`rsp_target`=1). Otherwise the access reaches the level-1 register (`rsp_target`=0).
- R8: Under the primary encoding at level 3, the access always reaches the level-1 register, with `rsp_target`=0.
- R9: `rsp_class` is 0x18 for both trap outcomes and 0 for all other outcomes.
- R10: Under the alias encoding at level 1, `nv_ctl`=3'b101 redirects to offset 0x828. Otherwise, `nv_ctl[0]`=1 traps to level 2. Any other value is undefined.
- R11: Under the alias encoding at levels 2 and 3, `host_mode`=0 is undefined. At level 2, the R2 and R5 checks then apply. An access that passes reaches the level-1 register, with `rsp_target`=0.
- R12: `rsp_outcome` is one-hot, with bit 0 = undefined, bit 1 = trap to level 2, bit 2 = trap to level 3, bit 3 = memory redirect, and bit 4 = register access. `rsp_valid` pulses in the cycle after each `req_valid`. Without a request, the outputs hold their values.
- R13: Synchronous reset clears `rsp_valid`, `rsp_outcome`, `rsp_class` and `rsp_target` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_alias | input | 1 | 1 = alias encoding, 0 = primary encoding |
| req_level | input | 2 | Current privilege level (0 to 3) |
| l2_enabled | input | 1 | Level 2 enabled in the current security state |
| l3_present | input | 1 | Level 3 implemented |
| sec_ns | input | 1 | Non-secure state bit |
| sec_ext | input | 1 | Extended security-state bit |
| own_ctl | input | 2 | Level-3 buffer-ownership control |
| own_ext | input | 1 | Ownership extension bit |
| realm_impl | input | 1 | Realm feature implemented |
| undef_prio | input | 1 | Ownership mismatch is undefined with top priority |
| dd_undef | input | 1 | Late ownership mismatch is undefined instead of trapping |
| fgt_impl | input | 1 | Fine-grained trap feature implemented |
| fgt_enable | input | 1 | Level-3 gate for fine-grained traps |
| fgt_rd_trap | input | 1 | Fine-grained read trap bit |
| fgt_wr_trap | input | 1 | Fine-grained write trap bit |
| coarse_trap | input | 1 | Coarse profiling trap bit |
| nv_ctl | input | 3 | Effective nested-virtualization bits |
| host_mode | input | 1 | Level 2 running in host mode |
| rsp_valid | output | 1 | Result valid pulse |
| rsp_outcome | output | 5 | One-hot outcome |
| rsp_class | output | 6 | Syndrome class |
| rsp_target | output | 12 | Memory offset, or register select (0 = level 1, 1 = level 2) |

## Verification
A wrong priority inside the decision chain shows at the ports as a wrong one-hot outcome bit one cycle after the strobe. A typical case is a coarse trap winning over an ownership mismatch. A mis-steered register path shows as a wrong `rsp_target` in that same cycle. A stale capture register shows as an outcome that changes when no strobe was given, or as a missing valid pulse.

The bench drives a long pseudo-random sweep across every input bit, with a new request in every cycle. It compares each result against a model written from the requirements, so that each branch of the chain is reached many times.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int OUT_W = 5;
  typedef logic [OUT_W-1:0] outcome_t;

  localparam outcome_t OC_UNDEF   = 5'b00001;
  localparam outcome_t OC_TRAP_L2 = 5'b00010;
  localparam outcome_t OC_TRAP_L3 = 5'b00100;
  localparam outcome_t OC_MEM     = 5'b01000;
  localparam outcome_t OC_REG     = 5'b10000;

  typedef enum logic [1:0] {
    LVL_USER = 2'd0,
    LVL_KERN = 2'd1,
    LVL_HYP  = 2'd2,
    LVL_MON  = 2'd3
  } lvl_e;

  typedef struct packed {
    outcome_t oc;
    logic     hyp_reg;
  } verdict_t;

  typedef struct packed {
    lvl_e       lvl;
    logic       write;
    logic       l2_en;
    logic       l3_here;
    logic       ns;
    logic       ext;
    logic [1:0] own;
    logic       own_ext;
    logic       realm;
    logic       undef_prio;
    logic       dd_undef;
    logic       fgt_impl;
    logic       fgt_en;
    logic       fgt_rd;
    logic       fgt_wr;
    logic       coarse;
    logic [2:0] nv;
    logic       host;
  } ctx_t;
endpackage

// File: rtl/pmc_owner_gate.sv
module pmc_owner_gate
  import pmc_pkg::*;
(
  input  ctx_t ctx,
  output logic hard_undef,
  output logic late_hit,
  output logic late_undef
);
  logic mismatch;

  always_comb begin
    mismatch = ctx.l3_here &&
               (!ctx.own[0] ||
                (ctx.own[1] != ctx.ns) ||
                (ctx.realm && (ctx.own_ext != ctx.ext)));
    hard_undef = mismatch && ctx.undef_prio;
    late_hit   = mismatch;
    late_undef = ctx.dd_undef;
  end
endmodule

// File: rtl/pmc_primary_path.sv
module pmc_primary_path
  import pmc_pkg::*;
(
  input  ctx_t     ctx,
  input  logic     hard_undef,
  input  logic     late_hit,
  input  logic     late_undef,
  output verdict_t v
);
  logic fgt_bit;
  logic fgt_hit;
  logic coarse_hit;
  outcome_t late_oc;

  always_comb begin
    fgt_bit    = ctx.write ? ctx.fgt_wr : ctx.fgt_rd;
    fgt_hit    = ctx.l2_en && ctx.fgt_impl && (!ctx.l3_here || ctx.fgt_en) && fgt_bit;
    coarse_hit = ctx.l2_en && ctx.coarse;
    late_oc    = late_undef ? OC_UNDEF : OC_TRAP_L3;

    v.oc      = OC_UNDEF;
    v.hyp_reg = 1'b0;
    unique case (ctx.lvl)
      LVL_USER: v.oc = OC_UNDEF;
      LVL_KERN: begin
        if (hard_undef)          v.oc = OC_UNDEF;
        else if (fgt_hit)        v.oc = OC_TRAP_L2;
        else if (coarse_hit)     v.oc = OC_TRAP_L2;
        else if (late_hit)       v.oc = late_oc;
        else if (ctx.nv == 3'b111) v.oc = OC_MEM;
        else                     v.oc = OC_REG;
      end
      LVL_HYP: begin
        if (hard_undef)    v.oc = OC_UNDEF;
        else if (late_hit) v.oc = late_oc;
        else begin
          v.oc      = OC_REG;
          v.hyp_reg = ctx.host;
        end
      end
      LVL_MON: v.oc = OC_REG;
      default: v.oc = OC_UNDEF;
    endcase
  end
endmodule

// File: rtl/pmc_alias_path.sv
module pmc_alias_path
  import pmc_pkg::*;
(
  input  ctx_t     ctx,
  input  logic     hard_undef,
  input  logic     late_hit,
  input  logic     late_undef,
  output verdict_t v
);
  always_comb begin
    v.oc      = OC_UNDEF;
    v.hyp_reg = 1'b0;
    unique case (ctx.lvl)
      LVL_USER: v.oc = OC_UNDEF;
      LVL_KERN: begin
        if (ctx.nv == 3'b101) v.oc = OC_MEM;
        else if (ctx.nv[0])   v.oc = OC_TRAP_L2;
        else                  v.oc = OC_UNDEF;
      end
      LVL_HYP: begin
        if (!ctx.host)      v.oc = OC_UNDEF;
        else if (hard_undef) v.oc = OC_UNDEF;
        else if (late_hit)   v.oc = late_undef ? OC_UNDEF : OC_TRAP_L3;
        else                 v.oc = OC_REG;
      end
      LVL_MON: v.oc = ctx.host ? OC_REG : OC_UNDEF;
      default: v.oc = OC_UNDEF;
    endcase
  end
endmodule

// File: rtl/pmc_access_gate.sv
module pmc_access_gate
  import pmc_pkg::*;
#(
  parameter int          EC_W     = 6,
  parameter int          TGT_W    = 12,
  parameter logic [5:0]  TRAP_EC  = 6'h18,
  parameter logic [11:0] MEM_SLOT = 12'h828
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_alias,
  input  logic [1:0]       req_level,
  input  logic             l2_enabled,
  input  logic             l3_present,
  input  logic             sec_ns,
  input  logic             sec_ext,
  input  logic [1:0]       own_ctl,
  input  logic             own_ext,
  input  logic             realm_impl,
  input  logic             undef_prio,
  input  logic             dd_undef,
  input  logic             fgt_impl,
  input  logic             fgt_enable,
  input  logic             fgt_rd_trap,
  input  logic             fgt_wr_trap,
  input  logic             coarse_trap,
  input  logic [2:0]       nv_ctl,
  input  logic             host_mode,
  output logic             rsp_valid,
  output logic [OUT_W-1:0] rsp_outcome,
  output logic [EC_W-1:0]  rsp_class,
  output logic [TGT_W-1:0] rsp_target
);
  localparam logic [EC_W-1:0]  EC_VAL  = EC_W'(TRAP_EC);
  localparam logic [TGT_W-1:0] MEM_VAL = TGT_W'(MEM_SLOT);
  localparam logic [TGT_W-1:0] HYP_SEL = TGT_W'(1);

  ctx_t     ctx;
  logic     hard_undef, late_hit, late_undef;
  verdict_t v_pri, v_ali, v_sel;
  logic [EC_W-1:0]  class_d;
  logic [TGT_W-1:0] target_d;

  always_comb begin
    ctx.lvl        = lvl_e'(req_level);
    ctx.write      = req_write;
    ctx.l2_en      = l2_enabled;
    ctx.l3_here    = l3_present;
    ctx.ns         = sec_ns;
    ctx.ext        = sec_ext;
    ctx.own        = own_ctl;
    ctx.own_ext    = own_ext;
    ctx.realm      = realm_impl;
    ctx.undef_prio = undef_prio;
    ctx.dd_undef   = dd_undef;
    ctx.fgt_impl   = fgt_impl;
    ctx.fgt_en     = fgt_enable;
    ctx.fgt_rd     = fgt_rd_trap;
    ctx.fgt_wr     = fgt_wr_trap;
    ctx.coarse     = coarse_trap;
    ctx.nv         = nv_ctl;
    ctx.host       = host_mode;
  end

  pmc_owner_gate u_owner (
    .ctx        (ctx),
    .hard_undef (hard_undef),
    .late_hit   (late_hit),
    .late_undef (late_undef)
  );

  pmc_primary_path u_primary (
    .ctx        (ctx),
    .hard_undef (hard_undef),
    .late_hit   (late_hit),
    .late_undef (late_undef),
    .v          (v_pri)
  );

  pmc_alias_path u_alias (
    .ctx        (ctx),
    .hard_undef (hard_undef),
    .late_hit   (late_hit),
    .late_undef (late_undef),
    .v          (v_ali)
  );

  always_comb begin
    v_sel    = req_alias ? v_ali : v_pri;
    class_d  = (v_sel.oc == OC_TRAP_L2 || v_sel.oc == OC_TRAP_L3) ? EC_VAL : '0;
    if (v_sel.oc == OC_MEM)                    target_d = MEM_VAL;
    else if (v_sel.oc == OC_REG && v_sel.hyp_reg) target_d = HYP_SEL;
    else                                       target_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_outcome <= '0;
      rsp_class   <= '0;
      rsp_target  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_outcome <= v_sel.oc;
        rsp_class   <= class_d;
        rsp_target  <= target_d;
      end
    end
  end
endmodule

// File: rtl/pmc_access_gate_chk.sv
module pmc_access_gate_chk #(
  parameter int          EC_W     = 6,
  parameter int          TGT_W    = 12,
  parameter logic [5:0]  TRAP_EC  = 6'h18,
  parameter logic [11:0] MEM_SLOT = 12'h828
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_write,
  input logic             req_alias,
  input logic [1:0]       req_level,
  input logic             l2_enabled,
  input logic             l3_present,
  input logic             sec_ns,
  input logic             sec_ext,
  input logic [1:0]       own_ctl,
  input logic             own_ext,
  input logic             realm_impl,
  input logic             undef_prio,
  input logic             dd_undef,
  input logic             fgt_impl,
  input logic             fgt_enable,
  input logic             fgt_rd_trap,
  input logic             fgt_wr_trap,
  input logic             coarse_trap,
  input logic [2:0]       nv_ctl,
  input logic             host_mode,
  input logic             rsp_valid,
  input logic [4:0]       rsp_outcome,
  input logic [EC_W-1:0]  rsp_class,
  input logic [TGT_W-1:0] rsp_target
);
  p_user_undef_r1: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_level == 2'd0 |=> rsp_outcome == 5'b00001);

  p_mon_reg_r8: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_level == 2'd3 && !req_alias |=>
      rsp_outcome == 5'b10000 && rsp_target == '0);

  p_trap_class_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && (rsp_outcome[1] || rsp_outcome[2]) |-> rsp_class == EC_W'(TRAP_EC));

  p_alias_mem_r10: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_alias && req_level == 2'd1 && nv_ctl == 3'b101 |=>
      rsp_outcome == 5'b01000 && rsp_target == TGT_W'(MEM_SLOT));

  p_onehot_r12: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $countones(rsp_outcome) == 1);

  p_valid_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  p_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid && $stable(rsp_outcome) && $stable(rsp_target));
endmodule

bind pmc_access_gate pmc_access_gate_chk #(
  .EC_W(EC_W), .TGT_W(TGT_W), .TRAP_EC(TRAP_EC), .MEM_SLOT(MEM_SLOT)
) i_chk (.*);

// File: tb/test_pmc_access_gate.sv
`timescale 1ns/1ps
module test_pmc_access_gate;
  localparam int NVEC = 30000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [22:0] vec = '0;
  logic rsp_valid;
  logic [4:0] rsp_outcome;
  logic [5:0] rsp_class;
  logic [11:0] rsp_target;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pmc_access_gate i_pmc_access_gate (
    .clk(clk), .rst(rst), .req_valid(req_valid),
    .req_write(vec[2]), .req_alias(vec[3]), .req_level(vec[1:0]),
    .l2_enabled(vec[4]), .l3_present(vec[5]), .sec_ns(vec[6]), .sec_ext(vec[7]),
    .own_ctl(vec[9:8]), .own_ext(vec[10]), .realm_impl(vec[11]),
    .undef_prio(vec[12]), .dd_undef(vec[13]), .fgt_impl(vec[14]),
    .fgt_enable(vec[15]), .fgt_rd_trap(vec[16]), .fgt_wr_trap(vec[17]),
    .coarse_trap(vec[18]), .nv_ctl(vec[21:19]), .host_mode(vec[22]),
    .rsp_valid(rsp_valid), .rsp_outcome(rsp_outcome),
    .rsp_class(rsp_class), .rsp_target(rsp_target)
  );

  // Reference written from the requirement list.
  function automatic void model(input logic [22:0] v, output logic [4:0] oc,
                                output logic [11:0] tg, output string tag);
    logic [1:0] lv = v[1:0];
    logic bad = v[5] && (v[8] == 1'b0 || v[9] != v[6] || (v[11] && v[10] != v[7]));
    logic ftrap = (v[2] ? v[17] : v[16]) && v[4] && v[14] && (v[15] || !v[5]);
    logic [4:0] late = v[13] ? 5'b00001 : 5'b00100;
    tg = 12'h000;
    if (lv == 2'd0) begin oc = 5'b00001; tag = "R1"; return; end
    if (v[3]) begin
      if (lv == 2'd1) begin
        tag = "R10";
        if (v[21:19] == 3'b101) begin oc = 5'b01000; tg = 12'h828; end
        else oc = v[19] ? 5'b00010 : 5'b00001;
        return;
      end
      tag = "R11";
      if (!v[22]) begin oc = 5'b00001; return; end
      if (lv == 2'd2 && bad) begin oc = v[12] ? 5'b00001 : late; return; end
      oc = 5'b10000;
      return;
    end
    if (lv == 2'd3) begin oc = 5'b10000; tag = "R8"; return; end
    if (bad && v[12]) begin oc = 5'b00001; tag = "R2"; return; end
    if (lv == 2'd1 && ftrap) begin oc = 5'b00010; tag = "R3"; return; end
    if (lv == 2'd1 && v[4] && v[18]) begin oc = 5'b00010; tag = "R4"; return; end
    if (bad) begin oc = late; tag = "R5"; return; end
    if (lv == 2'd1) begin
      tag = "R6";
      if (v[21:19] == 3'b111) begin oc = 5'b01000; tg = 12'h828; end
      else oc = 5'b10000;
      return;
    end
    tag = "R7";
    oc = 5'b10000;
    tg = v[22] ? 12'h001 : 12'h000;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_run();
    end
  end

  initial begin
    logic [31:0] x = 32'h1234_5678;
    logic [22:0] held;
    logic [4:0] eoc;
    logic [11:0] etg;
    string tag;
    repeat (4) @(negedge clk);
    check(rsp_valid == 1'b0, "R13", "reset valid", rsp_valid, 0);
    check(rsp_outcome == 5'b0, "R13", "reset outcome", rsp_outcome, 0);
    check(rsp_class == 6'b0 && rsp_target == 12'b0, "R13", "reset class/target",
          {rsp_class, rsp_target}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R13", "idle valid after reset", rsp_valid, 0);

    for (int i = 0; i < NVEC; i++) begin
      x ^= x << 13; x ^= x >> 17; x ^= x << 5;
      vec = x[22:0];
      req_valid = 1'b1;
      held = vec;
      @(negedge clk);
      model(held, eoc, etg, tag);
      check(rsp_valid == 1'b1, "R12", "valid pulse", rsp_valid, 1);
      check(rsp_outcome == eoc, tag, "outcome", rsp_outcome, eoc);
      check(rsp_target == etg, tag, "target", rsp_target, etg);
      check(rsp_class == ((eoc == 5'b00010 || eoc == 5'b00100) ? 6'h18 : 6'h00),
            "R9", "class", rsp_class,
            (eoc == 5'b00010 || eoc == 5'b00100) ? 6'h18 : 6'h00);
    end

    // R3: the opposite-direction fine-grained bit has no effect (read, write bit set).
    vec = '0; vec[1:0] = 2'd1; vec[4] = 1'b1; vec[14] = 1'b1; vec[17] = 1'b1;
    @(negedge clk);
    check(rsp_outcome == 5'b10000, "R3", "read ignores write trap bit", rsp_outcome, 5'b10000);
    vec[2] = 1'b1;
    @(negedge clk);
    check(rsp_outcome == 5'b00010, "R3", "write uses write trap bit", rsp_outcome, 5'b00010);

    // R12: no request, outputs hold.
    req_valid = 1'b0;
    vec = '0;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R12", "no pulse without request", rsp_valid, 0);
    @(negedge clk);
    check(rsp_outcome == 5'b00010, "R12", "outcome held", rsp_outcome, 5'b00010);

    done = 1'b1;
    finish_run();
  end
endmodule